// File: doc/BRIEF.md
# Multi-Lane Record Framing Packer

This block collects bytes from eight independent byte-wide receive lanes, all on one clock. A lane flags the first byte of each record with a start marker. The start byte and the three bytes after it make up one four-byte record. The start byte is a marker and is thrown away. The remaining three bytes form a 24-bit payload, and the first of them received lands in the top byte.

Each lane has a small store for finished records. A framing controller serves the lanes in circular order. It sends out a single 32-bit stream made of packets. Each packet has one header word, then the data words, then one trailer word. Every data word carries the number of its source lane, so it can be identified further down the stream. A separate control bit marks the header and trailer.

A packet closes when an end-of-event request is pending and every lane store is empty. The trailer gives the number of data words in the packet, the number of records that were cut short, and whether any records were lost to a full store. Two copies of the block cover sixteen lanes.

Top module: `lane_packer`

## Requirements
- R1: A byte with valid and start high opens a record and is discarded. The next three valid bytes on that lane complete the record, and the first of them forms payload bits 23:16. Valid bytes without start, arriving while no record is open, are ignored.
- R2: A data word has ctl low, the payload in bits 23:0, the lane number in bits 27:24 and zero in bits 31:28.
- R3: A header word has ctl high, 0xB5 in bits 31:24, zero in bits 23:16 and an event number in bits 15:0. The event number is 0 after reset and rises by one for each trailer accepted.
- R4: A trailer word has ctl high and 0xE7 in bits 31:24. Bit 23 is the overflow flag and bits 22:20 are zero. Bits 19:16 hold the cut-record count, which saturates at 15. Bits 15:0 hold the number of data words in the packet.
- R5: A start byte that arrives while a record is open drops the partial record and adds one to the cut count. The start byte then opens a new record.
- R6: Each lane stores up to four finished records. A record that completes while its lane store is full is discarded and sets the overflow flag.
- R7: A word is transferred when valid and ready are both high. While valid is high and ready is low, valid stays high and the word and ctl hold steady.
- R8: After the previous data word from lane L, the next data word comes from the first lane holding a record, searching L+1, L+2 and so on with wrap-around. After reset the search starts at lane 0.
- R9: With no stored record and no pending end request, valid stays low. A header opens a packet once a record is stored or an end request is pending. The trailer follows once an end request is pending and all lane stores are empty, which makes an empty packet of a header and a trailer.
- R10: The trailer's error fields are fixed in the cycle the packet closes. Cuts and overflows in that cycle, or while the trailer waits, are reported in the next packet's trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| laneValid | input | 8 | Byte present on each lane |
| laneStart | input | 8 | Byte is the first of a record |
| laneBytes | input | 64 | Lane bytes, lane n in bits 8n+7:8n |
| eventEnd | input | 1 | One-cycle request to close the current packet |
| outReady | input | 1 | Downstream accepts the word |
| outValid | output | 1 | Output word present |
| outData | output | 32 | Header, data or trailer word |
| outCtl | output | 1 | High on header and trailer words |

## Verification
The collision that matters is between the error counters and the packet boundary. A cut record can be counted in the same cycle that the closing trailer takes its snapshot of the counters. The bench provokes this by emptying the stores, issuing an end request and presenting a lane restart on exactly the edge after the header is accepted. It then adds a second restart while the trailer is held stalled. The current trailer must show zero cuts, and the following packet's trailer must show two.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;
  localparam logic [7:0] HEAD_MARK = 8'hB5;
  localparam logic [7:0] TRAIL_MARK = 8'hE7;
  localparam int PAY_W = 24;
  localparam int CUT_W = 4;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HEAD,
    ST_DATA,
    ST_TRAIL
  } packState_t;

  typedef struct packed {
    logic showHead;
    logic showData;
    logic showTrail;
    logic popData;
    logic trailLoad;
    logic trailDone;
  } packStrobe_t;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0] wrIdx, rdIdx;
  logic [AW:0] fill;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] idx);
    return (idx == AW'(DEPTH - 1)) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx <= '0;
      rdIdx <= '0;
      fill  <= '0;
    end else begin
      if (push) wrIdx <= bump(wrIdx);
      if (pop) rdIdx <= bump(rdIdx);
      fill <= fill + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign headData = store[rdIdx];
  assign empty = (fill == '0);
  assign full = (fill == (AW+1)'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty); // R7
endmodule

// File: rtl/pack_datapath.sv
module pack_datapath
  import lane_pack_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_LANES-1:0]         laneValid,
  input  logic [NUM_LANES-1:0]         laneStart,
  input  logic [NUM_LANES*8-1:0]       laneBytes,
  input  packStrobe_t                  strobe,
  input  logic [$clog2(NUM_LANES)-1:0] servLane,
  output logic [NUM_LANES-1:0]         laneHas,
  output logic [31:0]                  wordOut
);
  localparam int SUM_W = $clog2(NUM_LANES + 1);
  localparam int WIDE_W = CUT_W + SUM_W;
  localparam logic [CUT_W-1:0] CUT_MAX = '1;

  logic [NUM_LANES-1:0] cutHit, ovfHit;
  logic [PAY_W-1:0] headArr [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [1:0] byteIdx;
    logic inRec;
    logic [15:0] gath;
    logic [7:0] byteIn;
    logic take, recDone, isFull, isEmpty, doPush, doPop;

    assign byteIn = laneBytes[g*8 +: 8];
    assign take = laneValid[g] && (laneStart[g] || inRec);
    assign recDone = take && !laneStart[g] && (byteIdx == 2'd3);
    assign cutHit[g] = laneValid[g] && laneStart[g] && inRec;
    assign doPush = recDone && !isFull;
    assign ovfHit[g] = recDone && isFull;
    assign doPop = strobe.popData && (servLane == g);
    assign laneHas[g] = !isEmpty;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        byteIdx <= '0;
        inRec   <= 1'b0;
        gath    <= '0;
      end else if (take) begin
        if (laneStart[g]) begin
          inRec   <= 1'b1;
          byteIdx <= 2'd1;
        end else begin
          gath    <= {gath[7:0], byteIn};
          byteIdx <= byteIdx + 2'd1;
          if (byteIdx == 2'd3) inRec <= 1'b0;
        end
      end
    end

    lane_fifo #(.WIDTH(PAY_W), .DEPTH(FIFO_DEPTH)) uFifo (
      .clk(clk), .rstN(rstN), .push(doPush), .pushData({gath, byteIn}),
      .pop(doPop), .headData(headArr[g]), .empty(isEmpty), .full(isFull)
    );
  end

  logic [SUM_W-1:0] cutSum;
  always_comb begin
    cutSum = '0;
    for (int i = 0; i < NUM_LANES; i++) cutSum = cutSum + SUM_W'(cutHit[i]);
  end

  logic [CUT_W-1:0] cutCnt, trailCut, cutBase;
  logic [WIDE_W-1:0] cutWide;
  logic ovfFlag, trailOvf;
  logic [CNT_W-1:0] wordCnt, eventCnt;

  assign cutBase = strobe.trailLoad ? '0 : cutCnt;
  assign cutWide = WIDE_W'(cutBase) + WIDE_W'(cutSum);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cutCnt   <= '0;
      trailCut <= '0;
      ovfFlag  <= 1'b0;
      trailOvf <= 1'b0;
      wordCnt  <= '0;
      eventCnt <= '0;
    end else begin
      cutCnt  <= (cutWide > WIDE_W'(CUT_MAX)) ? CUT_MAX : cutWide[CUT_W-1:0];
      ovfFlag <= (ovfFlag && !strobe.trailLoad) || (|ovfHit);
      if (strobe.trailLoad) begin
        trailCut <= cutCnt;
        trailOvf <= ovfFlag;
      end
      if (strobe.trailDone) begin
        wordCnt  <= '0;
        eventCnt <= eventCnt + 1'b1;
      end else if (strobe.popData) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  always_comb begin
    wordOut = '0;
    if (strobe.showHead)
      wordOut = {HEAD_MARK, 8'h00, eventCnt};
    else if (strobe.showTrail)
      wordOut = {TRAIL_MARK, trailOvf, 3'b000, trailCut, wordCnt};
    else if (strobe.showData)
      wordOut = {4'h0, 4'(servLane), headArr[servLane]};
  end

  AST_CUT_MONO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.trailLoad |=> cutCnt >= $past(cutCnt)); // R5
endmodule

// File: rtl/pack_control.sv
module pack_control
  import lane_pack_pkg::*;
#(
  parameter int NUM_LANES = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         eventEnd,
  input  logic                         outReady,
  input  logic [NUM_LANES-1:0]         laneHas,
  output packStrobe_t                  strobe,
  output logic [$clog2(NUM_LANES)-1:0] servLane,
  output logic                         outValid,
  output logic                         outCtl
);
  localparam int LANE_W = $clog2(NUM_LANES);

  packState_t state, stateNxt;
  logic closePend, anyData, curHas, accept;
  logic [LANE_W-1:0] ptr, ptrNext;

  assign anyData = |laneHas;
  assign curHas = laneHas[ptr];
  assign outCtl = (state == ST_HEAD) || (state == ST_TRAIL);
  assign outValid = outCtl || ((state == ST_DATA) && curHas);
  assign accept = outValid && outReady;
  assign ptrNext = (ptr == LANE_W'(NUM_LANES - 1)) ? '0 : ptr + 1'b1;
  assign servLane = ptr;

  always_comb begin
    strobe.showHead  = (state == ST_HEAD);
    strobe.showData  = (state == ST_DATA);
    strobe.showTrail = (state == ST_TRAIL);
    strobe.popData   = (state == ST_DATA) && curHas && outReady;
    strobe.trailLoad = (state == ST_DATA) && closePend && !anyData;
    strobe.trailDone = (state == ST_TRAIL) && outReady;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (anyData || closePend) stateNxt = ST_HEAD;
      ST_HEAD:  if (accept) stateNxt = ST_DATA;
      ST_DATA:  if (strobe.trailLoad) stateNxt = ST_TRAIL;
      ST_TRAIL: if (accept) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      closePend <= 1'b0;
      ptr       <= '0;
    end else begin
      state     <= stateNxt;
      closePend <= eventEnd || (closePend && !strobe.trailDone);
      if (state == ST_DATA && ((curHas && outReady) || (!curHas && anyData)))
        ptr <= ptrNext;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) && outValid && !outReady |=> $stable(ptr)); // R8
endmodule

// File: rtl/lane_packer.sv
module lane_packer
  import lane_pack_pkg::*;
#(
  parameter int NUM_LANES = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_LANES-1:0]   laneValid,
  input  logic [NUM_LANES-1:0]   laneStart,
  input  logic [NUM_LANES*8-1:0] laneBytes,
  input  logic                   eventEnd,
  input  logic                   outReady,
  output logic                   outValid,
  output logic [31:0]            outData,
  output logic                   outCtl
);
  packStrobe_t strobe;
  logic [$clog2(NUM_LANES)-1:0] servLane;
  logic [NUM_LANES-1:0] laneHas;

  pack_control #(.NUM_LANES(NUM_LANES)) uCtl (
    .clk(clk), .rstN(rstN), .eventEnd(eventEnd), .outReady(outReady),
    .laneHas(laneHas), .strobe(strobe), .servLane(servLane),
    .outValid(outValid), .outCtl(outCtl)
  );

  pack_datapath #(.NUM_LANES(NUM_LANES), .FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .laneValid(laneValid), .laneStart(laneStart),
    .laneBytes(laneBytes), .strobe(strobe), .servLane(servLane),
    .laneHas(laneHas), .wordOut(outData)
  );

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outCtl)); // R7
  AST_DATA_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outCtl |-> outData[31:28] == 4'h0); // R2
  AST_FRAME_MARK: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outCtl |-> (outData[31:24] == HEAD_MARK) || (outData[31:24] == TRAIL_MARK)); // R3
endmodule

// File: tb/sim_lane_packer.sv
module sim_lane_packer;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN;
  logic [NL-1:0] laneValid, laneStart;
  logic [NL*8-1:0] laneBytes;
  logic eventEnd, outReady, outValid, outCtl;
  logic [31:0] outData;

  int checks = 0;
  int errors = 0;
  logic [32:0] gotQ[$];
  logic [32:0] expQ[$];

  lane_packer u0 (
    .clk(clk), .rstN(rstN), .laneValid(laneValid), .laneStart(laneStart),
    .laneBytes(laneBytes), .eventEnd(eventEnd), .outReady(outReady),
    .outValid(outValid), .outData(outData), .outCtl(outCtl)
  );

  function automatic logic [32:0] hdrW(int evt);
    return {1'b1, 8'hB5, 8'h00, 16'(evt)};
  endfunction
  function automatic logic [32:0] trlW(bit ovf, int cut, int cnt);
    return {1'b1, 8'hE7, ovf, 3'b000, 4'(cut), 16'(cnt)};
  endfunction
  function automatic logic [32:0] datW(int lane, logic [23:0] pay);
    return {1'b0, 4'h0, 4'(lane), pay};
  endfunction

  task automatic check(bit ok, string req, logic [32:0] act, logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic putByte(int l, bit st, logic [7:0] b);
    @(negedge clk);
    laneValid[l] = 1'b1;
    laneStart[l] = st;
    laneBytes[l*8 +: 8] = b;
    @(negedge clk);
    laneValid[l] = 1'b0;
    laneStart[l] = 1'b0;
  endtask

  task automatic putRecord(int l, logic [23:0] p);
    putByte(l, 1'b1, 8'h5A);
    putByte(l, 1'b0, p[23:16]);
    putByte(l, 1'b0, p[15:8]);
    putByte(l, 1'b0, p[7:0]);
  endtask

  task automatic endEvent();
    @(negedge clk); eventEnd = 1'b1;
    @(negedge clk); eventEnd = 1'b0;
  endtask

  // Collects one packet with a stalling ready pattern; checks hold (R7).
  task automatic drainPacket(string req);
    bit done = 0;
    bit prevStall = 0;
    logic [32:0] prevW = '0;
    gotQ.delete();
    for (int k = 0; k < 400 && !done; k++) begin
      @(negedge clk); #1;
      if (prevStall)
        check(outValid && ({outCtl, outData} == prevW), "R7 hold", {outCtl, outData}, prevW);
      outReady = (k % 3 != 1);
      #1;
      if (outValid && outReady) begin
        gotQ.push_back({outCtl, outData});
        if (outCtl && outData[31:24] == 8'hE7) done = 1;
      end
      prevStall = outValid && !outReady;
      prevW = {outCtl, outData};
    end
    @(negedge clk); outReady = 1'b0;
    check(done, {req, " R9 packet closed"}, 33'(done), 33'd1);
  endtask

  task automatic compareQ(string req);
    check(gotQ.size() == expQ.size(), {req, " word count"}, 33'(gotQ.size()), 33'(expQ.size()));
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++)
      check(gotQ[i] === expQ[i], req, gotQ[i], expQ[i]);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(!outValid, "R9 idle after reset", 33'(outValid), 33'd0);
  endtask

  task automatic testBasic();
    putByte(2, 1'b0, 8'h77);        // R1 ignored outside a record
    putRecord(2, 24'h112233);
    putByte(2, 1'b0, 8'h99);        // R1 ignored after completion
    endEvent();
    drainPacket("R1 R2 R3 R4 basic");
    expQ = '{hdrW(0), datW(2, 24'h112233), trlW(0, 0, 1)};
    compareQ("R1 R2 R3 R4 basic");
  endtask

  task automatic testRoundRobin();
    putRecord(5, 24'hA1A1A1);
    putRecord(1, 24'hB2B2B2);
    putRecord(6, 24'hC3C3C3);
    putRecord(5, 24'hD4D4D4);
    endEvent();
    drainPacket("R8 round robin");
    // last served lane was 2: search 3,4,5 -> 5, 6, wrap to 1, then 5
    expQ = '{hdrW(1), datW(5, 24'hA1A1A1), datW(6, 24'hC3C3C3),
             datW(1, 24'hB2B2B2), datW(5, 24'hD4D4D4), trlW(0, 0, 4)};
    compareQ("R8 round robin");
  endtask

  task automatic testCut();
    putByte(3, 1'b1, 8'h5A);
    putByte(3, 1'b0, 8'hEE);
    putRecord(3, 24'h445566);
    endEvent();
    drainPacket("R5 cut record");
    expQ = '{hdrW(2), datW(3, 24'h445566), trlW(0, 1, 1)};
    compareQ("R5 cut record");
  endtask

  task automatic testOverflow();
    for (int i = 1; i <= 5; i++) putRecord(0, 24'(i));
    endEvent();
    drainPacket("R6 overflow");
    expQ = '{hdrW(3), datW(0, 24'h1), datW(0, 24'h2), datW(0, 24'h3),
             datW(0, 24'h4), trlW(1, 0, 4)};
    compareQ("R6 overflow");
  endtask

  task automatic testCollision();
    bit seen = 0;
    putByte(4, 1'b1, 8'h5A);
    putByte(4, 1'b0, 8'h10);
    endEvent();
    gotQ.delete();
    for (int k = 0; k < 50 && !seen; k++) begin
      @(negedge clk); outReady = 1'b0; #1;
      if (outValid && outCtl && outData[31:24] == 8'hB5) begin
        gotQ.push_back({outCtl, outData});
        outReady = 1'b1;
        seen = 1;
      end
    end
    // header accepted next edge; the cut lands on the close (snapshot) edge
    @(negedge clk);
    outReady = 1'b0;
    laneValid[4] = 1'b1; laneStart[4] = 1'b1; laneBytes[4*8 +: 8] = 8'h5A;
    @(negedge clk);
    laneValid[4] = 1'b0; laneStart[4] = 1'b0;
    #1;
    check(outValid && ({outCtl, outData} == trlW(0, 0, 0)), "R10 trailer snapshot",
          {outCtl, outData}, trlW(0, 0, 0));
    putByte(4, 1'b1, 8'h5A);        // second cut while trailer is stalled
    #1;
    check(outValid && ({outCtl, outData} == trlW(0, 0, 0)), "R10 trailer frozen",
          {outCtl, outData}, trlW(0, 0, 0));
    @(negedge clk); outReady = 1'b1;
    #1; gotQ.push_back({outCtl, outData});
    @(negedge clk); outReady = 1'b0;
    expQ = '{hdrW(4), trlW(0, 0, 0)};
    compareQ("R9 empty packet");
    putByte(4, 1'b0, 8'hAB);
    putByte(4, 1'b0, 8'hCD);
    putByte(4, 1'b0, 8'hEF);
    endEvent();
    drainPacket("R10 carried errors");
    expQ = '{hdrW(5), datW(4, 24'hABCDEF), trlW(0, 2, 1)};
    compareQ("R10 carried errors");
  endtask

  initial begin
    rstN = 1'b0;
    laneValid = '0; laneStart = '0; laneBytes = '0;
    eventEnd = 1'b0; outReady = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testRoundRobin();
    testCut();
    testOverflow();
    testCollision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog R9 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule